// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects up to eight interrupt request lines, decides which of them may interrupt the processor, and tells the processor which one to serve. The processor reaches it through a byte-wide register port that has a single address bit. It holds three registers: the captured requests, the per-input mask, and the set of inputs that are currently being serviced. When a request is pending, unmasked, and more urgent than anything already in service, the block raises its interrupt output. The processor then pulses an acknowledge. In response, the block picks the winning input, records it as in service, and presents an 8-bit vector. The vector is a programmable base with the input number placed in its low bits.

Software configures the block with a short start-up sequence. Writing a byte with the address bit low and data bit 4 set opens the sequence. Between one and three further words follow with the address bit high. Once the sequence is complete, the block accepts run-time commands: mask writes, selection of the register to read back, and end-of-interrupt. A configuration word can select automatic end of service, in which case an acknowledge never leaves an input marked as in service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask, request and in-service registers are zero, the interrupt output is low, read-back at address 0 shows the request register, and the configuration is edge-triggered with base 0.
- R2: A write at address 0 with data bit 4 set starts configuration. It clears the mask, request and in-service registers and returns read-back to the request register. It stores bit 3 (1 = level-triggered), bit 1 (1 = single controller, 0 = cascade) and bit 0 (1 = a mode word follows). The interrupt output stays low until the sequence ends.
- R3: During configuration, address-1 writes are taken in a fixed order. First comes the base word, whose bits 7..3 become vector bits 7..3. The cascade word is accepted only when bit 1 of the start word was 0, and it appears on `cascade_cfg`. The mode word is accepted only when bit 0 of the start word was 1, and its bits 4..0 appear on `mode_cfg`; otherwise `mode_cfg` is zero. After the last expected word the block runs normally.
- R4: While running, an address-1 write loads the mask, and an address-1 read returns it. A masked input never raises the interrupt output.
- R5: While running, writing 0x0B at address 0 makes address-0 reads return the request register, and writing 0x0A makes them return the in-service register.
- R6: Input 0 has the highest priority. The interrupt output is high when an unmasked request exists whose index is lower than that of every in-service bit.
- R7: An acknowledge while the interrupt output is high sets the in-service bit of the winning input. From the next cycle `ack_vec` holds the base in bits 7..3 and the input number in bits 2..0.
- R8: In edge mode, a request bit is set by a rising input and cleared by its acknowledge, so a line held high does not request again. In level mode, the request register follows the inputs each cycle.
- R9: Writing 0x20 at address 0 while running clears only the lowest-index set bit of the in-service register.
- R10: With mode-word bit 1 set (automatic end of service), an acknowledge leaves the in-service register unchanged.
- R11: An acknowledge while the interrupt output is low returns the base with input number 7 and changes no register.
- R12: Other address-0 bytes with bit 4 clear have no effect on any register or on the read-back selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per byte |
| bus_addr | input | 1 | Register address bit |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| irq_lines | input | 8 | Interrupt request inputs |
| irq_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Acknowledge pulse from the processor |
| ack_vec | output | 8 | Vector from the most recent acknowledge |
| cascade_cfg | output | 8 | Stored cascade word |
| mode_cfg | output | 5 | Stored mode word bits |

## Verification
The hardest states to reach are those with nested service, where a more urgent input interrupts while a less urgent one is still in service and end-of-interrupt then has to retire them in the right order. The stimulus reaches these states by acknowledging a low-priority input and then raising more urgent and less urgent lines before issuing end-of-interrupt commands one at a time. A behavioural model predicts the interrupt output, the read-back and the vector on every cycle. The sequence is repeated under both edge and level capture, and also with automatic end of service and with each optional configuration word skipped.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        PH_RUN = 2'd0,
        PH_W2  = 2'd1,
        PH_W3  = 2'd2,
        PH_W4  = 2'd3
    } phase_t;

    localparam logic [7:0] CMD_SEL_REQ = 8'h0B;
    localparam logic [7:0] CMD_SEL_SVC = 8'h0A;
    localparam logic [7:0] CMD_EOI     = 8'h20;

    localparam int START_BIT  = 4;
    localparam int LEVEL_BIT  = 3;
    localparam int SINGLE_BIT = 1;
    localparam int NEED4_BIT  = 0;
    localparam int AUTO_BIT   = 1;
    localparam int MODE_W     = 5;

endpackage

// File: rtl/irqc_first_set.sv
module irqc_first_set #(
    parameter int N = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec_i,
    output logic [N-1:0]  upto_o,
    output logic [IW-1:0] idx_o
);

    logic [N-1:0] first;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_chain
            if (g == 0) begin : g_head
                assign upto_o[g] = vec_i[g];
                assign first[g]  = vec_i[g];
            end else begin : g_tail
                assign upto_o[g] = upto_o[g-1] | vec_i[g];
                assign first[g]  = vec_i[g] & ~upto_o[g-1];
            end
        end
    endgenerate

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) idx_o = idx_o | IW'(i);
        end
    end

endmodule

// File: rtl/irqc_cfg_seq.sv
module irqc_cfg_seq
    import irqc_pkg::*;
#(
    parameter int DW    = 8,
    parameter int IDX_W = 3,
    localparam int BASE_W = DW - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DW-1:0]     wdata,
    output logic              busy_o,
    output logic              restart_o,
    output logic              level_o,
    output logic              auto_eoi_o,
    output logic [BASE_W-1:0] base_o,
    output logic [DW-1:0]     casc_o,
    output logic [MODE_W-1:0] mode_o
);

    typedef struct packed {
        phase_t            ph;
        logic              level;
        logic              single;
        logic              need4;
        logic [BASE_W-1:0] base;
        logic [DW-1:0]     casc;
        logic [MODE_W-1:0] mode;
    } seq_t;

    seq_t seq_d, seq_q;
    logic restart;

    always_comb begin
        seq_d   = seq_q;
        restart = wr_en & ~addr & wdata[START_BIT];
        if (restart) begin
            seq_d.ph     = PH_W2;
            seq_d.level  = wdata[LEVEL_BIT];
            seq_d.single = wdata[SINGLE_BIT];
            seq_d.need4  = wdata[NEED4_BIT];
            seq_d.casc   = '0;
            seq_d.mode   = '0;
        end else if (wr_en && addr) begin
            case (seq_q.ph)
                PH_W2: begin
                    seq_d.base = wdata[DW-1:IDX_W];
                    if (!seq_q.single)     seq_d.ph = PH_W3;
                    else if (seq_q.need4)  seq_d.ph = PH_W4;
                    else                   seq_d.ph = PH_RUN;
                end
                PH_W3: begin
                    seq_d.casc = wdata;
                    seq_d.ph   = seq_q.need4 ? PH_W4 : PH_RUN;
                end
                PH_W4: begin
                    seq_d.mode = wdata[MODE_W-1:0];
                    seq_d.ph   = PH_RUN;
                end
                default: seq_d.ph = PH_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{ph: PH_RUN, level: 1'b0, single: 1'b1, need4: 1'b0,
                       base: '0, casc: '0, mode: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o     = (seq_q.ph != PH_RUN);
    assign restart_o  = restart;
    assign level_o    = seq_q.level;
    assign auto_eoi_o = seq_q.mode[AUTO_BIT];
    assign base_o     = seq_q.base;
    assign casc_o     = seq_q.casc;
    assign mode_o     = seq_q.mode;

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int N_IN = 8,
    parameter int DW   = 8,
    localparam int IDX_W  = $clog2(N_IN),
    localparam int BASE_W = DW - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [N_IN-1:0]   irq_lines,
    output logic              irq_out,
    input  logic              ack,
    output logic [DW-1:0]     ack_vec,
    output logic [DW-1:0]     cascade_cfg,
    output logic [MODE_W-1:0] mode_cfg
);

    typedef struct packed {
        logic [N_IN-1:0] irr;
        logic [N_IN-1:0] imr;
        logic [N_IN-1:0] isr;
        logic [N_IN-1:0] prev;
        logic            sel_isr;
        logic [DW-1:0]   vec;
    } core_t;

    core_t st_d, st_q;

    logic              busy, restart, level, auto_eoi;
    logic [BASE_W-1:0] base;

    logic [N_IN-1:0]  isr_upto, cand, cand_upto;
    logic [IDX_W-1:0] isr_idx, win_idx;
    logic             win_any, grant, run_cmd, eoi_hit;

    // Signals exposed for the bound checker
    logic [N_IN-1:0] imr_w, isr_w;

    irqc_cfg_seq #(.DW(DW), .IDX_W(IDX_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .busy_o     (busy),
        .restart_o  (restart),
        .level_o    (level),
        .auto_eoi_o (auto_eoi),
        .base_o     (base),
        .casc_o     (cascade_cfg),
        .mode_o     (mode_cfg)
    );

    irqc_first_set #(.N(N_IN)) u_svc_pick (
        .vec_i  (st_q.isr),
        .upto_o (isr_upto),
        .idx_o  (isr_idx)
    );

    assign cand = st_q.irr & ~st_q.imr & ~isr_upto;

    irqc_first_set #(.N(N_IN)) u_win_pick (
        .vec_i  (cand),
        .upto_o (cand_upto),
        .idx_o  (win_idx)
    );

    assign win_any = cand_upto[N_IN-1];
    assign irq_out = win_any & ~busy;
    assign grant   = ack & irq_out;
    assign run_cmd = bus_wr & ~bus_addr & ~bus_wdata[START_BIT] & ~busy;
    assign eoi_hit = run_cmd & (bus_wdata == CMD_EOI);

    always_comb begin
        st_d      = st_q;
        st_d.prev = irq_lines;

        // request capture
        if (level) begin
            st_d.irr = irq_lines;
        end else begin
            if (grant) st_d.irr[win_idx] = 1'b0;
            st_d.irr = st_d.irr | (irq_lines & ~st_q.prev);
        end

        // in-service update: end-of-interrupt first, then acknowledge
        if (eoi_hit && isr_upto[N_IN-1]) st_d.isr[isr_idx] = 1'b0;
        if (grant && !auto_eoi)          st_d.isr[win_idx] = 1'b1;

        // mask and read-back selection
        if (bus_wr && bus_addr && !busy) st_d.imr = bus_wdata[N_IN-1:0];
        if (run_cmd && bus_wdata == CMD_SEL_REQ) st_d.sel_isr = 1'b0;
        if (run_cmd && bus_wdata == CMD_SEL_SVC) st_d.sel_isr = 1'b1;

        // vector
        if (ack) st_d.vec = grant ? {base, win_idx} : {base, {IDX_W{1'b1}}};

        if (restart) begin
            st_d.irr     = '0;
            st_d.imr     = '0;
            st_d.isr     = '0;
            st_d.sel_isr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (bus_addr)         bus_rdata = DW'(st_q.imr);
        else if (st_q.sel_isr) bus_rdata = DW'(st_q.isr);
        else                   bus_rdata = DW'(st_q.irr);
    end

    assign ack_vec = st_q.vec;
    assign imr_w   = st_q.imr;
    assign isr_w   = st_q.isr;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         busy,
    input logic         restart,
    input logic         irq_out,
    input logic         ack,
    input logic         auto_eoi,
    input logic         eoi_hit,
    input logic         bus_wr,
    input logic         bus_addr,
    input logic [N-1:0] wdata,
    input logic [N-1:0] imr,
    input logic [N-1:0] isr
);

    a_r2_quiet_while_config: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !irq_out);

    a_r4_full_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&imr) |-> !irq_out);

    a_r4_mask_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && !busy) |=> (imr == $past(wdata)));

    a_r9_eoi_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_hit && !ack && (isr != '0)) |=>
            ($countones(isr) == $countones($past(isr)) - 1));

    a_r7_ack_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_out && !auto_eoi && !eoi_hit && !restart) |=>
            ($countones(isr) == $countones($past(isr)) + 1));

    a_r10_auto_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && auto_eoi && !eoi_hit && !restart) |=> (isr == $past(isr)));

endmodule

bind prio_irq_ctrl irqc_checker #(.N(N_IN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .restart  (restart),
    .irq_out  (irq_out),
    .ack      (ack),
    .auto_eoi (auto_eoi),
    .eoi_hit  (eoi_hit),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wdata    (bus_wdata[N_IN-1:0]),
    .imr      (imr_w),
    .isr      (isr_w)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] irq_lines = 8'h00;
    logic       irq_out;
    logic       ack = 1'b0;
    logic [7:0] ack_vec;
    logic [7:0] cascade_cfg;
    logic [4:0] mode_cfg;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    prio_irq_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq_lines   (irq_lines),
        .irq_out     (irq_out),
        .ack         (ack),
        .ack_vec     (ack_vec),
        .cascade_cfg (cascade_cfg),
        .mode_cfg    (mode_cfg)
    );

    // ---------------- behavioural reference model ----------------
    bit [7:0] m_irr, m_imr, m_isr, m_prev, m_vec, m_casc;
    bit [4:0] m_base, m_mode;
    bit       m_sel, m_level, m_single, m_need4;
    int       m_phase;   // 0 run, 2 base word, 3 cascade word, 4 mode word

    function automatic int m_winner();
        if (m_phase != 0) return -1;
        for (int i = 0; i < 8; i++) begin
            if (m_isr[i]) return -1;
            if (m_irr[i] && !m_imr[i]) return i;
        end
        return -1;
    endfunction

    function automatic bit [7:0] m_read(bit a);
        if (a) return m_imr;
        return m_sel ? m_isr : m_irr;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_irr = 0; m_imr = 0; m_isr = 0; m_prev = 0; m_vec = 0; m_casc = 0;
            m_base = 0; m_mode = 0; m_sel = 0; m_level = 0; m_single = 1;
            m_need4 = 0; m_phase = 0;
        end else begin
            automatic int       w     = m_winner();
            automatic bit       start = bus_wr && !bus_addr && bus_wdata[4];
            automatic bit       cmd   = bus_wr && !bus_addr && !bus_wdata[4] && (m_phase == 0);
            automatic bit [7:0] n_irr = m_irr;
            automatic bit [7:0] n_isr = m_isr;
            automatic bit [7:0] n_imr = m_imr;
            automatic bit       n_sel = m_sel;
            if (m_level) n_irr = irq_lines;
            else begin
                if (ack && w >= 0) n_irr[w] = 1'b0;
                n_irr = n_irr | (irq_lines & ~m_prev);
            end
            if (cmd && bus_wdata == 8'h20) begin
                automatic bit done = 0;
                for (int i = 0; i < 8; i++)
                    if (!done && n_isr[i]) begin n_isr[i] = 1'b0; done = 1; end
            end
            if (ack && w >= 0 && !m_mode[1]) n_isr[w] = 1'b1;
            if (bus_wr && bus_addr && m_phase == 0) n_imr = bus_wdata;
            if (cmd && bus_wdata == 8'h0B) n_sel = 0;
            if (cmd && bus_wdata == 8'h0A) n_sel = 1;
            if (ack) m_vec = {m_base, (w >= 0) ? 3'(w) : 3'd7};
            if (start) begin
                n_irr = 0; n_imr = 0; n_isr = 0; n_sel = 0;
                m_level = bus_wdata[3]; m_single = bus_wdata[1]; m_need4 = bus_wdata[0];
                m_casc = 0; m_mode = 0; m_phase = 2;
            end else if (bus_wr && bus_addr) begin
                if (m_phase == 2) begin
                    m_base  = bus_wdata[7:3];
                    m_phase = !m_single ? 3 : (m_need4 ? 4 : 0);
                end else if (m_phase == 3) begin
                    m_casc  = bus_wdata;
                    m_phase = m_need4 ? 4 : 0;
                end else if (m_phase == 4) begin
                    m_mode  = bus_wdata[4:0];
                    m_phase = 0;
                end
            end
            m_irr = n_irr; m_isr = n_isr; m_imr = n_imr; m_sel = n_sel;
            m_prev = irq_lines;
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            check("R6 irq_out vs model", int'(irq_out), int'(m_winner() >= 0));
            check("R5 read-back vs model", int'(bus_rdata), int'(m_read(bus_addr)));
            check("R7 vector vs model", int'(ack_vec), int'(m_vec));
            check("R3 cascade word vs model", int'(cascade_cfg), int'(m_casc));
            check("R3 mode word vs model", int'(mode_cfg), int'(m_mode));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic bus_write(input bit a, input bit [7:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_wdata = 8'h00;
    endtask

    task automatic pulse_ack();
        @(negedge clk); ack = 1;
        @(negedge clk); ack = 0;
    endtask

    task automatic drive_lines(input bit [7:0] v);
        @(negedge clk); irq_lines = v;
        @(negedge clk);
    endtask

    task automatic set_addr(input bit a);
        @(negedge clk); bus_addr = a;
    endtask

    task automatic look(input string tag, input int act, input int exp);
        #1 check(tag, act, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        set_addr(1);
        look("R1 mask zero after reset", bus_rdata, 8'h00);
        look("R1 irq low after reset", irq_out, 0);
        set_addr(0);
        look("R1 request read-back zero", bus_rdata, 8'h00);

        // edge, cascade, mode word follows
        bus_write(0, 8'h11);
        drive_lines(8'h04);
        look("R2 irq held low while configuring", irq_out, 0);
        bus_write(1, 8'h90);
        bus_write(1, 8'h04);
        bus_write(1, 8'h01);
        look("R3 cascade word stored", cascade_cfg, 8'h04);
        look("R3 mode word stored", mode_cfg, 5'h01);
        look("R6 pending input raises irq", irq_out, 1);
        pulse_ack();
        look("R7 vector base plus input 2", ack_vec, 8'h92);
        look("R6 irq drops while input 2 in service", irq_out, 0);
        set_addr(0);
        bus_write(0, 8'h0A);
        look("R5 in-service read-back", bus_rdata, 8'h04);
        drive_lines(8'h06);
        look("R6 more urgent input nests", irq_out, 1);
        pulse_ack();
        look("R7 vector for input 1", ack_vec, 8'h91);
        look("R7 two bits in service", bus_rdata, 8'h06);
        drive_lines(8'h26);
        look("R6 less urgent input blocked", irq_out, 0);
        bus_write(0, 8'h20);
        look("R9 eoi clears lowest index only", bus_rdata, 8'h04);
        look("R6 input 5 still blocked by input 2", irq_out, 0);
        bus_write(0, 8'h20);
        look("R9 second eoi empties service", bus_rdata, 8'h00);
        look("R6 input 5 now raises irq", irq_out, 1);
        pulse_ack();
        look("R7 vector for input 5", ack_vec, 8'h95);
        bus_write(0, 8'h20);

        // masking
        bus_write(1, 8'hFF);
        drive_lines(8'h27);
        look("R4 masked input gives no irq", irq_out, 0);
        look("R4 mask read-back", bus_rdata, 8'hFF);
        bus_write(1, 8'h00);
        look("R4 unmasked input raises irq", irq_out, 1);
        pulse_ack();
        look("R6 input 0 wins", ack_vec, 8'h90);
        bus_write(0, 8'h20);
        look("R8 held line does not request again", irq_out, 0);
        set_addr(0);
        bus_write(0, 8'h0B);
        look("R8 request register empty", bus_rdata, 8'h00);

        // ignored command
        drive_lines(8'h00);
        drive_lines(8'h08);
        look("R8 edge captured on input 3", bus_rdata, 8'h08);
        bus_write(0, 8'h07);
        look("R12 unknown command leaves read-back", bus_rdata, 8'h08);
        pulse_ack();
        look("R7 vector for input 3", ack_vec, 8'h93);
        bus_write(0, 8'h20);

        // acknowledge with nothing eligible
        pulse_ack();
        look("R11 spurious vector", ack_vec, 8'h97);
        look("R11 request register unchanged", bus_rdata, 8'h00);

        // level, single, automatic end of service
        drive_lines(8'h00);
        bus_write(1, 8'h33);
        bus_write(0, 8'h1B);
        bus_write(1, 8'h40);
        look("R2 mask cleared by start word", bus_rdata, 8'h00);
        bus_write(1, 8'h03);
        look("R3 cascade word skipped in single mode", cascade_cfg, 8'h00);
        look("R3 mode word taken directly", mode_cfg, 5'h03);
        drive_lines(8'h08);
        look("R8 level input raises irq", irq_out, 1);
        pulse_ack();
        look("R7 vector with new base", ack_vec, 8'h43);
        set_addr(0);
        bus_write(0, 8'h0A);
        look("R10 auto end leaves service empty", bus_rdata, 8'h00);
        look("R8 level input still requests", irq_out, 1);
        drive_lines(8'h00);
        @(negedge clk);
        look("R8 level input released", irq_out, 0);

        // single, no mode word
        bus_write(0, 8'h12);
        bus_write(1, 8'h20);
        bus_write(1, 8'h5A);
        look("R3 word after base loads the mask", bus_rdata, 8'h5A);
        look("R3 mode word cleared", mode_cfg, 5'h00);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule